// File: doc/BRIEF.md
# Shared Tag-Line Wakeup Broadcaster

This block carries destination register tags from the functional units to the wakeup logic of an issue queue when the block has only half as many broadcast lines as issue slots. Each pair of functional units owns one broadcast line. Each unit in the pair has its own tag latch. A tag-producing issue loads the unit's latch. In the next cycle the tag is driven onto the pair's line, together with a valid qualifier.

Both latches of a pair can hold a tag at the same time. In that case one tag is driven and the other is held back for a later cycle. A per-pair waiting indicator is visible to the issue logic. It tells the issue logic that a held tag sits in the pair, so that the issue logic can avoid steering a new result-producing instruction onto the held latch. A flush throws away every latched tag. The tag comparison inside the issue queue belongs to a different block.

Top module: `shared_tagline_bcast`

## Requirements
- R1: There are ISSUE_W/2 lines. Line p serves units 2p and 2p+1, and a line carries at most one tag per cycle.
- R2: A unit loads its latch when `iss_vld_i` and `iss_prod_i` are both high for that unit. If the latch was accepted, the tag appears on the line, with `line_vld_o` high, in the cycle after the issue. The line is idle in the cycle after that unless other tags are pending.
- R3: If both units of a pair load in the same cycle and no tag is waiting, the lower-numbered unit's tag is driven first. The other tag is driven in the following cycle.
- R4: `wait_ind_o[p]` is high exactly during the cycles in which line p drives a tag that was held back in an earlier cycle. It returns low once no held tag remains.
- R5: A held tag is driven before any newer tag in the other latch of the same pair.
- R6: An issue with `iss_prod_i` low, or with `iss_vld_i` low, loads nothing. A tag that is already latched is left untouched.
- R7: A tag-producing issue is accepted only when the unit's latch is empty or is being driven in that same cycle. Otherwise the issue is discarded, and the held tag is still driven later.
- R8: While `flush_i` is high, every line is idle. In the next cycle all latches and indicators are empty, including tags issued during the flush cycle.
- R9: After reset every line is idle and every indicator is low.
- R10: The pairs operate independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Discard all latched tags |
| iss_vld_i | input | ISSUE_W | Per-unit issue valid |
| iss_prod_i | input | ISSUE_W | Per-unit flag: the issued instruction writes a register |
| iss_tag_i | input | ISSUE_W*TAG_W | Per-unit destination tag, unit u at bits u*TAG_W upward |
| line_vld_o | output | ISSUE_W/2 | Per-line broadcast valid |
| line_tag_o | output | ISSUE_W/2*TAG_W | Per-line broadcast tag, line p at bits p*TAG_W upward |
| wait_ind_o | output | ISSUE_W/2 | Per-pair waiting-tag indicator |

## Verification
The hardest state to reach from the ports has three parts at once: a tag is held in one latch, a fresh tag sits in the other latch, and a further issue is aimed at the latch whose tag is not driven. Only in this state do the priority of the held tag and the discard rule meet. The stimulus gets there in three steps. Both units of a pair issue together. In the next cycle the unit being drained issues again. In the cycle after that, the unit whose latch has just become the held one issues again. The bench then follows the line cycle by cycle until it goes idle, and confirms that the discarded tag never appears.

// File: rtl/stb_pkg.sv
package stb_pkg;
  // Which latch of a pair drives the shared line
  typedef enum logic {
    PICK_LO = 1'b0,
    PICK_HI = 1'b1
  } pick_e;
endpackage

// File: rtl/stb_pair_arb.sv
module stb_pair_arb
  import stb_pkg::*;
(
  input  logic [1:0] occ_i,
  input  logic       ind_i,
  input  pick_e      wsel_i,
  output logic       any_o,
  output pick_e      bsel_o
);
  always_comb begin
    any_o = |occ_i;
    if (ind_i) begin
      bsel_o = wsel_i;          // held tag goes first
    end else if (occ_i[0]) begin
      bsel_o = PICK_LO;         // simultaneous fresh tags: lower unit first
    end else begin
      bsel_o = PICK_HI;
    end
  end
endmodule

// File: rtl/stb_tag_slot.sv
module stb_tag_slot #(
  parameter int TAG_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             ld_i,
  input  logic             drain_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             occ_o,
  output logic [TAG_W-1:0] tag_o
);
  logic             occ_q, occ_d;
  logic [TAG_W-1:0] tag_q, tag_d;

  always_comb begin
    if (flush_i) begin
      occ_d = 1'b0;
    end else if (ld_i) begin
      occ_d = 1'b1;
    end else begin
      occ_d = occ_q & ~drain_i;
    end
    tag_d = tag_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= 1'b0;
      tag_q <= '0;
    end else begin
      occ_q <= occ_d;
      if (ld_i) begin
        tag_q <= tag_d;
      end
    end
  end

  assign occ_o = occ_q;
  assign tag_o = tag_q;

  AST_SLOT_UNLOADED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_i |=> $stable(tag_q)) else $error("slot tag changed without load"); // R6
endmodule

// File: rtl/stb_pair_lane.sv
module stb_pair_lane
  import stb_pkg::*;
#(
  parameter int TAG_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush_i,
  input  logic [1:0]         iss_vld_i,
  input  logic [1:0]         iss_prod_i,
  input  logic [2*TAG_W-1:0] iss_tag_i,
  output logic               line_vld_o,
  output logic [TAG_W-1:0]   line_tag_o,
  output logic               wait_ind_o
);
  logic [1:0]       occ;
  logic [1:0]       drain;
  logic [1:0]       ld;
  logic [TAG_W-1:0] slot_tag [2];
  logic             any;
  pick_e            bsel;
  pick_e            wsel_q, wsel_d;
  logic             ind_q, ind_d;
  logic             sel_idx, oth_idx;
  logic             hold_now;
  logic [TAG_W-1:0] held_tag;

  stb_pair_arb u_arb (
    .occ_i  (occ),
    .ind_i  (ind_q),
    .wsel_i (wsel_q),
    .any_o  (any),
    .bsel_o (bsel)
  );

  assign sel_idx = bsel;
  assign oth_idx = ~sel_idx;

  for (genvar u = 0; u < 2; u++) begin : g_slot
    localparam logic UID = 1'(u);
    assign drain[u] = any && (sel_idx == UID);
    assign ld[u]    = iss_vld_i[u] & iss_prod_i[u] & (~occ[u] | drain[u]);

    stb_tag_slot #(.TAG_W(TAG_W)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush_i (flush_i),
      .ld_i    (ld[u]),
      .drain_i (drain[u]),
      .tag_i   (iss_tag_i[u*TAG_W +: TAG_W]),
      .occ_o   (occ[u]),
      .tag_o   (slot_tag[u])
    );
  end

  always_comb begin
    hold_now = any && occ[oth_idx] && !flush_i;
    held_tag = slot_tag[oth_idx];
    ind_d    = hold_now;
    wsel_d   = pick_e'(oth_idx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ind_q  <= 1'b0;
      wsel_q <= PICK_LO;
    end else begin
      ind_q <= ind_d;
      if (hold_now) begin
        wsel_q <= wsel_d;
      end
    end
  end

  assign line_vld_o = any & ~flush_i;
  assign line_tag_o = slot_tag[sel_idx];
  assign wait_ind_o = ind_q;

  AST_HELD_TAG_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    hold_now |=> (ind_q && (line_tag_o == $past(held_tag)) && (line_vld_o || flush_i)))
    else $error("held tag not driven next"); // R5
  AST_IND_DRIVES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (ind_q && !flush_i) |-> line_vld_o) else $error("indicator without line"); // R4
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (!ind_q && (occ == 2'b00))) else $error("flush left state"); // R8
endmodule

// File: rtl/shared_tagline_bcast.sv
module shared_tagline_bcast #(
  parameter int ISSUE_W = 6,
  parameter int TAG_W   = 7
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             flush_i,
  input  logic [ISSUE_W-1:0]               iss_vld_i,
  input  logic [ISSUE_W-1:0]               iss_prod_i,
  input  logic [ISSUE_W*TAG_W-1:0]         iss_tag_i,
  output logic [ISSUE_W/2-1:0]             line_vld_o,
  output logic [(ISSUE_W/2)*TAG_W-1:0]     line_tag_o,
  output logic [ISSUE_W/2-1:0]             wait_ind_o
);
  localparam int NLINE = ISSUE_W / 2;

  for (genvar p = 0; p < NLINE; p++) begin : g_lane
    stb_pair_lane #(.TAG_W(TAG_W)) u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush_i    (flush_i),
      .iss_vld_i  (iss_vld_i[2*p +: 2]),
      .iss_prod_i (iss_prod_i[2*p +: 2]),
      .iss_tag_i  (iss_tag_i[2*p*TAG_W +: 2*TAG_W]),
      .line_vld_o (line_vld_o[p]),
      .line_tag_o (line_tag_o[p*TAG_W +: TAG_W]),
      .wait_ind_o (wait_ind_o[p])
    );
  end

  AST_FLUSH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |-> (line_vld_o == '0)) else $error("line driven in flush"); // R8
endmodule

// File: tb/shared_tagline_bcast_tb_top.sv
module shared_tagline_bcast_tb_top;
  localparam int ISSUE_W = 6;
  localparam int TAG_W   = 7;
  localparam int NLINE   = ISSUE_W / 2;
  localparam time CLK_PERIOD = 10ns;

  logic                       clk = 1'b0;
  logic                       rst_n;
  logic                       flush;
  logic [ISSUE_W-1:0]         iss_vld;
  logic [ISSUE_W-1:0]         iss_prod;
  logic [ISSUE_W*TAG_W-1:0]   iss_tag;
  logic [NLINE-1:0]           line_vld;
  logic [NLINE*TAG_W-1:0]     line_tag;
  logic [NLINE-1:0]           wait_ind;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shared_tagline_bcast #(.ISSUE_W(ISSUE_W), .TAG_W(TAG_W)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_i    (flush),
    .iss_vld_i  (iss_vld),
    .iss_prod_i (iss_prod),
    .iss_tag_i  (iss_tag),
    .line_vld_o (line_vld),
    .line_tag_o (line_tag),
    .wait_ind_o (wait_ind)
  );

  task automatic clear_in();
    flush    = 1'b0;
    iss_vld  = '0;
    iss_prod = '0;
    iss_tag  = '0;
  endtask

  task automatic issue(input int u, input int tag, input bit prod);
    iss_vld[u]  = 1'b1;
    iss_prod[u] = prod;
    iss_tag[u*TAG_W +: TAG_W] = TAG_W'(tag);
  endtask

  // advance one cycle, drop the inputs, let outputs settle
  task automatic step();
    @(negedge clk);
    clear_in();
    #1;
  endtask

  task automatic cmp(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_line(input string req, input int p, input bit ev, input int et, input bit ei);
    cmp(req, $sformatf("line%0d vld", p), int'(line_vld[p]), int'(ev));
    if (ev) cmp(req, $sformatf("line%0d tag", p), int'(line_tag[p*TAG_W +: TAG_W]), et);
    cmp(req, $sformatf("line%0d ind", p), int'(wait_ind[p]), int'(ei));
  endtask

  task automatic t_reset();
    for (int p = 0; p < NLINE; p++) chk_line("R9", p, 1'b0, 0, 1'b0);
  endtask

  task automatic t_single();
    issue(3, 'h15, 1'b1);
    step();
    chk_line("R2", 1, 1'b1, 'h15, 1'b0);   // unit 3 -> line 1 (R1)
    chk_line("R1", 0, 1'b0, 0, 1'b0);
    step();
    chk_line("R2", 1, 1'b0, 0, 1'b0);
  endtask

  task automatic t_collide();
    issue(0, 'h11, 1'b1);
    issue(1, 'h22, 1'b1);
    step();
    chk_line("R3", 0, 1'b1, 'h11, 1'b0);
    step();
    chk_line("R4", 0, 1'b1, 'h22, 1'b1);
    step();
    chk_line("R4", 0, 1'b0, 0, 1'b0);
  endtask

  task automatic t_priority();
    issue(0, 'h31, 1'b1);
    issue(1, 'h32, 1'b1);
    step();
    chk_line("R3", 0, 1'b1, 'h31, 1'b0);
    issue(0, 'h33, 1'b1);                  // latch 0 drains now: accepted
    step();
    chk_line("R5", 0, 1'b1, 'h32, 1'b1);
    issue(0, 'h34, 1'b1);                  // latch 0 held, not driven: discarded
    step();
    chk_line("R7", 0, 1'b1, 'h33, 1'b1);
    step();
    chk_line("R7", 0, 1'b0, 0, 1'b0);
  endtask

  task automatic t_noprod();
    issue(4, 'h3F, 1'b0);
    iss_prod[5] = 1'b1;
    iss_tag[5*TAG_W +: TAG_W] = TAG_W'('h2A);
    step();
    chk_line("R6", 2, 1'b0, 0, 1'b0);
    issue(4, 'h41, 1'b1);
    issue(5, 'h42, 1'b1);
    step();
    chk_line("R6", 2, 1'b1, 'h41, 1'b0);
    issue(5, 'h7E, 1'b0);                  // non-producing issue to held latch
    step();
    chk_line("R6", 2, 1'b1, 'h42, 1'b1);
    step();
    chk_line("R6", 2, 1'b0, 0, 1'b0);
  endtask

  task automatic t_flush();
    issue(2, 'h51, 1'b1);
    issue(3, 'h52, 1'b1);
    step();
    chk_line("R3", 1, 1'b1, 'h51, 1'b0);
    flush = 1'b1;
    issue(2, 'h53, 1'b1);
    #1;
    chk_line("R8", 1, 1'b0, 0, 1'b0);
    step();
    chk_line("R8", 1, 1'b0, 0, 1'b0);
  endtask

  task automatic t_indep();
    issue(0, 'h61, 1'b1);
    issue(1, 'h62, 1'b1);
    issue(5, 'h65, 1'b1);
    step();
    chk_line("R10", 0, 1'b1, 'h61, 1'b0);
    chk_line("R10", 2, 1'b1, 'h65, 1'b0);
    chk_line("R10", 1, 1'b0, 0, 1'b0);
    step();
    chk_line("R10", 0, 1'b1, 'h62, 1'b1);
    chk_line("R10", 2, 1'b0, 0, 1'b0);
    step();
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    clear_in();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_single();
    t_collide();
    t_priority();
    t_noprod();
    t_flush();
    t_indep();
    finish_run();
  end
endmodule